// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block switches one gated logic domain between its powered and unpowered states on command. A one-cycle start pulse, qualified by a direction bit, launches either a bring-up or a tear-down. The sequencer then walks a fixed chain of steps on the domain's control outputs: two power switches, clock gating, isolation, an active-low reset and an SRAM power-down field. Between the steps it waits on the domain's two power-status inputs, on the SRAM acknowledge inputs and on a bus-protection handshake.

Each step changes one output in its own clock cycle, so the order can be followed cycle by cycle. Every wait is bounded by a cycle-count limit. When the limit runs out, the sequence stops, an error flag is raised, and the outputs keep the values they had reached. Parameters select the acknowledge mask and decide whether the SRAM steps and the bus-protection steps exist at all.

Top module: `pd_sequencer`

## Requirements
- R1: After reset the control vector `ctl_o` reads 0xF12: bit0 reset_n=0, bit1 isolate=1, bit2 primary switch=0, bit3 secondary switch=0, bit4 clock-off=1, bits 11:8 SRAM power-down all ones. `prot_req_o` equals 1 when protection is enabled and 0 otherwise. `busy_o`, `done_o` and `err_o` are 0.
- R2: A start with `dir_on_i`=1 sets bit2, then bit3, then waits until the domain is on. It then clears bit4, clears bit1, sets bit0 and clears bits 11:8, each in its own cycle, and ends with `ctl_o`=0x00D.
- R3: The domain counts as on only when both status inputs are 1. A mixed status keeps the bring-up waiting.
- R4: After bits 11:8 are cleared, the bring-up waits until every acknowledge bit selected by `ACK_MASK` reads 0. Unselected bits are ignored.
- R5: A start with `dir_on_i`=0 sets bits 11:8 and waits until every selected acknowledge bit reads 1. It then sets bit1, clears bit0, sets bit4, clears bit2 and clears bit3, each in its own cycle, and ends with `ctl_o`=0xF12.
- R6: A tear-down ends only when both status inputs are 0. A mixed status keeps it waiting.
- R7: With protection enabled, a tear-down first raises `prot_req_o` and waits for `prot_ack_i`=1 before any control bit changes. A bring-up lowers `prot_req_o` only after the acknowledge wait has passed, then waits for `prot_ack_i`=0.
- R8: Each wait lasts at most `TIMEOUT_CYC` sampled cycles. When the limit expires, `err_o` and `done_o` rise together, the block goes idle and `ctl_o` holds its last value. `err_o` clears when the next sequence is accepted.
- R9: At most one of bits 4:0 of `ctl_o` changes per clock cycle.
- R10: A start pulse that arrives while `busy_o` is 1 is ignored.
- R11: With `ACK_MASK`=0 the acknowledge wait passes in its first cycle. With protection disabled, `prot_req_o` stays 0 and no protection steps are taken. Such a bring-up, on a domain that is already reporting on, raises `done_o` 8 cycles after the accepting edge.
- R12: `done_o` is a one-cycle pulse at the end of every sequence, and `busy_o` falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle sequence request |
| dir_on_i | input | 1 | 1 = bring up, 0 = tear down |
| pwr_sta_i | input | 1 | First power-status input |
| pwr_sta2_i | input | 1 | Second power-status input |
| sram_ack_i | input | ACK_W | SRAM power-down acknowledge |
| prot_ack_i | input | 1 | Bus-protection handshake completion |
| ctl_o | output | SRAM_LO+SRAM_W | Domain control vector |
| prot_req_o | output | 1 | Bus-protection request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence ended (pulse) |
| err_o | output | 1 | Last sequence timed out |

## Verification
An accepted start moves `busy_o` on the accepting edge. Each action step then changes its control bit one edge later. A wait whose condition holds on an edge lets the next step act on the following edge, so a bring-up on a domain already reporting on ends 8 edges after acceptance, and a hung wait ends `TIMEOUT_CYC`+2 edges after acceptance. The bench model advances on the same rising edges and reads the status inputs, which the bench's plant only changes on falling edges. All outputs are compared on the falling edge after each rising edge. Latency checks count falling edges from the acceptance point.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  // Control vector bit positions (decoded by the domain's switch fabric)
  localparam int B_RSTN  = 0;
  localparam int B_ISO   = 1;
  localparam int B_PON   = 2;
  localparam int B_PON2  = 3;
  localparam int B_CKOFF = 4;
  localparam int SRAM_LO = 8;
  localparam int PWR_W   = 5;

  // Powered-off pattern of bits 4:0
  localparam logic [PWR_W-1:0] PWR_OFF = 5'b10010;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_U_PON, ST_U_PON2, ST_U_WON, ST_U_CKEN, ST_U_ISO, ST_U_RST,
    ST_U_SRAM, ST_U_WACK, ST_U_PROT, ST_U_WPROT,
    ST_D_PROT, ST_D_WPROT, ST_D_SRAM, ST_D_WACK,
    ST_D_ISO, ST_D_RST, ST_D_CKDIS, ST_D_PON, ST_D_PON2, ST_D_WOFF
  } seq_state_t;

  typedef enum logic [3:0] {
    OP_HOLD,
    OP_PON_SET, OP_PON2_SET, OP_CK_CLR, OP_ISO_CLR, OP_RST_REL,
    OP_SRAM_CLR, OP_PROT_CLR,
    OP_PROT_SET, OP_SRAM_SET, OP_ISO_SET, OP_RST_SET, OP_CK_SET,
    OP_PON_CLR, OP_PON2_CLR
  } ctl_op_t;

endpackage

// File: rtl/pd_status_eval.sv
module pd_status_eval #(
  parameter int              ACK_W    = 4,
  parameter logic [ACK_W-1:0] ACK_MASK = '1
) (
  input  logic             sta_a_i,
  input  logic             sta_b_i,
  input  logic [ACK_W-1:0] ack_i,
  output logic             all_on_o,
  output logic             all_off_o,
  output logic             ack_clear_o,
  output logic             ack_full_o
);

  logic [ACK_W-1:0] sel_hi;
  logic [ACK_W-1:0] sel_full;

  for (genvar i = 0; i < ACK_W; i++) begin : g_ack
    if (ACK_MASK[i]) begin : g_used
      assign sel_hi[i]   = ack_i[i];
      assign sel_full[i] = ack_i[i];
    end else begin : g_unused
      assign sel_hi[i]   = 1'b0;
      assign sel_full[i] = 1'b1;
    end
  end

  assign all_on_o    = sta_a_i & sta_b_i;
  assign all_off_o   = ~sta_a_i & ~sta_b_i;
  assign ack_clear_o = ~|sel_hi;
  assign ack_full_o  = &sel_full;

endmodule

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || expire_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/pd_ctrl_reg.sv
module pd_ctrl_reg
  import pd_seq_pkg::*;
#(
  parameter int SRAM_W   = 4,
  parameter bit USE_SRAM = 1'b1,
  parameter bit USE_PROT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctl_op_t                   op_i,
  output logic [SRAM_LO+SRAM_W-1:0] ctl_o,
  output logic                      prot_req_o
);

  logic [PWR_W-1:0]  pwr_q;
  logic [SRAM_W-1:0] pdn;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= PWR_OFF;
    end else begin
      unique case (op_i)
        OP_PON_SET:  pwr_q[B_PON]   <= 1'b1;
        OP_PON2_SET: pwr_q[B_PON2]  <= 1'b1;
        OP_CK_CLR:   pwr_q[B_CKOFF] <= 1'b0;
        OP_ISO_CLR:  pwr_q[B_ISO]   <= 1'b0;
        OP_RST_REL:  pwr_q[B_RSTN]  <= 1'b1;
        OP_ISO_SET:  pwr_q[B_ISO]   <= 1'b1;
        OP_RST_SET:  pwr_q[B_RSTN]  <= 1'b0;
        OP_CK_SET:   pwr_q[B_CKOFF] <= 1'b1;
        OP_PON_CLR:  pwr_q[B_PON]   <= 1'b0;
        OP_PON2_CLR: pwr_q[B_PON2]  <= 1'b0;
        default:     pwr_q <= pwr_q;
      endcase
    end
  end

  if (USE_SRAM) begin : g_sram
    logic [SRAM_W-1:0] pdn_q;
    always_ff @(posedge clk) begin
      if (rst)                     pdn_q <= '1;
      else if (op_i == OP_SRAM_CLR) pdn_q <= '0;
      else if (op_i == OP_SRAM_SET) pdn_q <= '1;
    end
    assign pdn = pdn_q;
  end else begin : g_nosram
    assign pdn = '0;
  end

  if (USE_PROT) begin : g_prot
    logic prot_q;
    always_ff @(posedge clk) begin
      if (rst)                      prot_q <= 1'b1;
      else if (op_i == OP_PROT_CLR) prot_q <= 1'b0;
      else if (op_i == OP_PROT_SET) prot_q <= 1'b1;
    end
    assign prot_req_o = prot_q;
  end else begin : g_noprot
    assign prot_req_o = 1'b0;
  end

  assign ctl_o = {pdn, {(SRAM_LO - PWR_W){1'b0}}, pwr_q};

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int               SRAM_W      = 4,
  parameter int               ACK_W       = 4,
  parameter logic [ACK_W-1:0] ACK_MASK    = 4'b0011,
  parameter bit               USE_SRAM    = 1'b1,
  parameter bit               USE_PROT    = 1'b1,
  parameter int               TIMEOUT_CYC = 1000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      dir_on_i,
  input  logic                      pwr_sta_i,
  input  logic                      pwr_sta2_i,
  input  logic [ACK_W-1:0]          sram_ack_i,
  input  logic                      prot_ack_i,
  output logic [SRAM_LO+SRAM_W-1:0] ctl_o,
  output logic                      prot_req_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o
);

  seq_state_t st_q, st_nxt;
  ctl_op_t    op;
  logic       in_wait, cond, finish, expire, abort;
  logic       all_on, all_off, ack_clear, ack_full;
  logic       done_q, err_q;

  pd_status_eval #(.ACK_W(ACK_W), .ACK_MASK(ACK_MASK)) u_stat (
    .sta_a_i    (pwr_sta_i),
    .sta_b_i    (pwr_sta2_i),
    .ack_i      (sram_ack_i),
    .all_on_o   (all_on),
    .all_off_o  (all_off),
    .ack_clear_o(ack_clear),
    .ack_full_o (ack_full)
  );

  pd_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run_i   (in_wait && !cond),
    .expire_o(expire)
  );

  pd_ctrl_reg #(.SRAM_W(SRAM_W), .USE_SRAM(USE_SRAM), .USE_PROT(USE_PROT)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .ctl_o     (ctl_o),
    .prot_req_o(prot_req_o)
  );

  always_comb begin
    st_nxt  = st_q;
    op      = OP_HOLD;
    in_wait = 1'b0;
    cond    = 1'b0;
    finish  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (dir_on_i)      st_nxt = ST_U_PON;
          else if (USE_PROT) st_nxt = ST_D_PROT;
          else if (USE_SRAM) st_nxt = ST_D_SRAM;
          else               st_nxt = ST_D_ISO;
        end
      end
      // ---- bring-up ----
      ST_U_PON:  begin op = OP_PON_SET;  st_nxt = ST_U_PON2; end
      ST_U_PON2: begin op = OP_PON2_SET; st_nxt = ST_U_WON;  end
      ST_U_WON: begin
        in_wait = 1'b1; cond = all_on;
        if (cond) st_nxt = ST_U_CKEN;
      end
      ST_U_CKEN: begin op = OP_CK_CLR;  st_nxt = ST_U_ISO; end
      ST_U_ISO:  begin op = OP_ISO_CLR; st_nxt = ST_U_RST; end
      ST_U_RST: begin
        op = OP_RST_REL;
        if (USE_SRAM)      st_nxt = ST_U_SRAM;
        else if (USE_PROT) st_nxt = ST_U_PROT;
        else begin finish = 1'b1; st_nxt = ST_IDLE; end
      end
      ST_U_SRAM: begin op = OP_SRAM_CLR; st_nxt = ST_U_WACK; end
      ST_U_WACK: begin
        in_wait = 1'b1; cond = ack_clear;
        if (cond) begin
          if (USE_PROT) st_nxt = ST_U_PROT;
          else begin finish = 1'b1; st_nxt = ST_IDLE; end
        end
      end
      ST_U_PROT: begin op = OP_PROT_CLR; st_nxt = ST_U_WPROT; end
      ST_U_WPROT: begin
        in_wait = 1'b1; cond = !prot_ack_i;
        if (cond) begin finish = 1'b1; st_nxt = ST_IDLE; end
      end
      // ---- tear-down ----
      ST_D_PROT: begin op = OP_PROT_SET; st_nxt = ST_D_WPROT; end
      ST_D_WPROT: begin
        in_wait = 1'b1; cond = prot_ack_i;
        if (cond) st_nxt = USE_SRAM ? ST_D_SRAM : ST_D_ISO;
      end
      ST_D_SRAM: begin op = OP_SRAM_SET; st_nxt = ST_D_WACK; end
      ST_D_WACK: begin
        in_wait = 1'b1; cond = ack_full;
        if (cond) st_nxt = ST_D_ISO;
      end
      ST_D_ISO:   begin op = OP_ISO_SET;  st_nxt = ST_D_RST;   end
      ST_D_RST:   begin op = OP_RST_SET;  st_nxt = ST_D_CKDIS; end
      ST_D_CKDIS: begin op = OP_CK_SET;   st_nxt = ST_D_PON;   end
      ST_D_PON:   begin op = OP_PON_CLR;  st_nxt = ST_D_PON2;  end
      ST_D_PON2:  begin op = OP_PON2_CLR; st_nxt = ST_D_WOFF;  end
      ST_D_WOFF: begin
        in_wait = 1'b1; cond = all_off;
        if (cond) begin finish = 1'b1; st_nxt = ST_IDLE; end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign abort = expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= abort ? ST_IDLE : st_nxt;
      done_q <= finish || abort;
      if (st_q == ST_IDLE && start_i) err_q <= 1'b0;
      else if (abort)                 err_q <= 1'b1;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R2
  clk_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_o[B_CKOFF] |-> (ctl_o[B_PON] && ctl_o[B_PON2]));

  // R3
  on_before_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_U_CKEN) |-> $past(pwr_sta_i && pwr_sta2_i));

  // R7
  prot_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_req_o) |-> (ctl_o[SRAM_LO +: SRAM_W] == '0));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ctl_o[PWR_W-1:0] ^ $past(ctl_o[PWR_W-1:0])) <= 1);

  // R10
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R12
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

endmodule

// File: tb/sim_pd_sequencer.sv
module sim_pd_sequencer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int         TMO  = 20;
  localparam logic [3:0] MASK = 4'b0011;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, start, dir_on, start1;
  logic        sta, sta2, prot_ack;
  logic [3:0]  ack;
  logic [11:0] ctl, ctl1;
  logic        prot, busy, done, err;
  logic        prot1, busy1, done1, err1;

  pd_sequencer #(.ACK_MASK(MASK), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .dir_on_i(dir_on),
    .pwr_sta_i(sta), .pwr_sta2_i(sta2), .sram_ack_i(ack), .prot_ack_i(prot_ack),
    .ctl_o(ctl), .prot_req_o(prot), .busy_o(busy), .done_o(done), .err_o(err));

  pd_sequencer #(.ACK_MASK(4'b0000), .USE_PROT(1'b0)) u1 (
    .clk(clk), .rst(rst), .start_i(start1), .dir_on_i(dir_on),
    .pwr_sta_i(sta), .pwr_sta2_i(sta2), .sram_ack_i(ack), .prot_ack_i(prot_ack),
    .ctl_o(ctl1), .prot_req_o(prot1), .busy_o(busy1), .done_o(done1), .err_o(err1));

  int    n_chk = 0, n_fail = 0;
  string cur = "R1";
  bit    cmp_en = 1'b0;

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", r, got, exp, $time);
    end
  endtask

  // ---------------- plant: status and handshakes follow the controls ----------------
  int  d_a = 1, d_b = 4, d_ack = 0, d_prot = 0;
  int  ca, cb, ck, cp;
  bit  hang = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      sta = 0; sta2 = 0; ack = 4'b1111; prot_ack = 1;
      ca = 0; cb = 0; ck = 0; cp = 0;
    end else begin
      if (sta != (ctl[2] && !hang)) begin
        if (ca >= d_a) begin sta = ~sta; ca = 0; end else ca++;
      end else ca = 0;
      if (sta2 != ctl[3]) begin
        if (cb >= d_b) begin sta2 = ~sta2; cb = 0; end else cb++;
      end else cb = 0;
      if (ack[0] != (|ctl[11:8])) begin
        if (ck >= d_ack) begin ack[1:0] = {2{|ctl[11:8]}}; ck = 0; end else ck++;
      end else ck = 0;
      ack[3:2] = 2'b11;
      if (prot_ack != prot) begin
        if (cp >= d_prot) begin prot_ack = prot; cp = 0; end else cp++;
      end else cp = 0;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [11:0] e_ctl;
  logic        e_prot, e_busy, e_done, e_err;

  function automatic bit m_cond(input int k);
    case (k)
      0: return sta && sta2;
      1: return (ack & MASK) == 4'b0000;
      2: return !prot_ack;
      3: return prot_ack;
      4: return (ack & MASK) == MASK;
      default: return !sta && !sta2;
    endcase
  endfunction

  task automatic m_bit(input int b, input bit v);
    @(posedge clk);
    e_ctl[b] = v;
  endtask

  task automatic m_wait(input int k, output bit ok);
    int n = 0;
    ok = 1'b0;
    forever begin
      @(posedge clk);
      if (m_cond(k)) begin ok = 1'b1; return; end
      if (n == TMO - 1) begin
        e_err = 1; e_done = 1; e_busy = 0;
        return;
      end
      n++;
    end
  endtask

  task automatic m_run(input bit up);
    bit ok;
    if (up) begin
      m_bit(2, 1); m_bit(3, 1);
      m_wait(0, ok); if (!ok) return;
      m_bit(4, 0); m_bit(1, 0); m_bit(0, 1);
      @(posedge clk); e_ctl[11:8] = 4'h0;
      m_wait(1, ok); if (!ok) return;
      @(posedge clk); e_prot = 0;
      m_wait(2, ok); if (!ok) return;
    end else begin
      @(posedge clk); e_prot = 1;
      m_wait(3, ok); if (!ok) return;
      @(posedge clk); e_ctl[11:8] = 4'hF;
      m_wait(4, ok); if (!ok) return;
      m_bit(1, 1); m_bit(0, 0); m_bit(4, 1); m_bit(2, 0); m_bit(3, 0);
      m_wait(5, ok); if (!ok) return;
    end
    e_done = 1; e_busy = 0;
  endtask

  initial begin : model
    e_ctl = 12'hF12; e_prot = 1; e_busy = 0; e_done = 0; e_err = 0;
    forever begin
      @(posedge clk);
      if (rst) begin
        e_ctl = 12'hF12; e_prot = 1; e_busy = 0; e_done = 0; e_err = 0;
      end else begin
        e_done = 0;
        if (start) begin
          e_busy = 1; e_err = 0;
          m_run(dir_on);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_en)
      chk(cur, {16'h0, ctl, prot, busy, done, err}, {16'h0, e_ctl, e_prot, e_busy, e_done, e_err});
  end

  // ---------------- stimulus ----------------
  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(input bit up);
    start = 1'b1; dir_on = up;
    tick;
    start = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 500 && !done; i++) tick;
  endtask

  task automatic run_tests;
    int m;
    rst = 1; start = 0; dir_on = 0; start1 = 0;
    repeat (4) tick;
    rst = 0; cmp_en = 1;
    tick;
    chk("R1", {ctl, prot, busy, done, err}, {12'hF12, 4'b1000});
    chk("R1", {prot1, busy1, done1, err1}, 4'b0000);

    // bring-up with staggered status
    cur = "R2"; pulse(1);
    for (int i = 0; i < 100 && !(sta && !sta2); i++) tick;
    chk("R3", {sta, sta2, busy, ctl[4]}, 4'b1011);
    wait_done;
    chk("R2", {ctl, prot, busy, done, err}, {12'h00D, 4'b0010});

    // tear-down with slow protection handshake
    d_prot = 3; cur = "R5"; pulse(0);
    for (int i = 0; i < 100 && !(prot && !prot_ack); i++) tick;
    chk("R7", {ctl, busy}, {12'h00D, 1'b1});
    for (int i = 0; i < 100 && !(!sta && sta2); i++) tick;
    chk("R6", {sta, sta2, busy}, 3'b011);
    wait_done;
    chk("R5", {ctl, prot, busy, done, err}, {12'hF12, 4'b1010});

    // bring-up with slow SRAM acknowledge, unselected bits stuck high
    d_ack = 3; cur = "R4"; pulse(1);
    for (int i = 0; i < 100 && !(ctl[11:8] == 4'h0 && ack[1:0] != 2'b00); i++) tick;
    chk("R4", {ack[1:0] != 2'b00, prot, busy}, 3'b111);
    wait_done;
    chk("R4", {ctl, err, ack[3:2]}, {12'h00D, 3'b011});

    // start while busy is ignored
    cur = "R10"; pulse(0);
    repeat (3) tick;
    start = 1; dir_on = 1; tick; start = 0;
    wait_done;
    chk("R10", {ctl, busy, err}, {12'hF12, 2'b00});
    repeat (2) tick;
    chk("R10", {ctl, busy}, {12'hF12, 1'b0});

    // timeout on the on-wait
    hang = 1; cur = "R8"; pulse(1);
    m = 0;
    while (!done && m < 500) begin tick; m++; end
    chk("R8", m, TMO + 2);
    chk("R8", {ctl, err, busy}, {12'hF1E, 2'b10});
    repeat (5) tick;
    chk("R8", {ctl, err, busy}, {12'hF1E, 2'b10});
    hang = 0; pulse(1);
    chk("R8", {err, busy}, 2'b01);
    wait_done;
    chk("R8", {ctl, err}, {12'h00D, 1'b0});

    // empty mask and no protection, domain already reporting on
    cur = "R11";
    start1 = 1; dir_on = 1; tick; start1 = 0;
    m = 0;
    while (!done1 && m < 500) begin tick; m++; end
    chk("R11", m, 8);
    chk("R11", {ctl1, prot1, err1}, {12'h00D, 2'b00});
    tick;
    chk("R12", {done1, busy1}, 2'b00);
    repeat (3) tick;
  endtask

  initial begin : main
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual hung expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule